// File: doc/BRIEF.md
# Saturated Transient Override Controller

This block sits between the digitized regulation error of a multi-phase buck converter and the high-side gate commands of its phase legs. The measured quantity mixes output voltage and total inductor current. It is scaled so that the loop presents a target output impedance. Each time a new sample arrives, the block takes the signed difference between that sample and a reference code. The difference is counted in ADC quantization bins, and the block sorts it into one of three drive modes.

When the error is small, the phase commands come straight from the linear PID/PWM path, and the auxiliary clamp switch stays open. A large overshoot (sample well above the reference) pulls every phase leg low and closes the clamp to ground so that it absorbs the excess inductor energy. A large undershoot (sample well below the reference) drives every phase leg to the input rail. The window is asymmetric: two bins on the high side and four bins on the low side. The chosen mode is also reported on a status output, so that the PID path can freeze its integrator while an override is in force.

The mode is held in a register and changes only on sample strobes. A direct jump between the two forced modes inserts a single clock in which all phase commands are low and the clamp is open.

Top module: `stv_override_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the mode is normal (`mode_o` = 2'b00), the clamp is open, and `phase_hi` follows `pwm_in`.
- R2: A strobed sample that exceeds the reference by more than OVER_BINS (default 2) bins selects the sink mode. From the cycle after the strobe edge, every `phase_hi` bit is 0 and `clamp_on` is 1.
- R3: A strobed sample that lies more than UNDER_BINS (default 4) bins below the reference selects the source mode. From the cycle after the strobe edge, every `phase_hi` bit is 1 and `clamp_on` is 0 (apart from the guard cycle of R7).
- R4: A strobed sample whose difference from the reference lies in [-UNDER_BINS, +OVER_BINS] selects normal mode: `phase_hi` equals `pwm_in` combinationally and `clamp_on` is 0.
- R5: The mode changes only at a clock edge where `sample_vld` is 1. Codes presented without the strobe have no effect on the mode or on the outputs.
- R6: The difference is computed as a signed value one bit wider than the codes, so extreme codes never wrap. Sample 1023 with reference 0 gives sink mode; sample 0 with reference 1023 gives source mode.
- R7: When a strobe moves the mode directly between sink and source, for exactly one clock after that edge every `phase_hi` bit is 0 and `clamp_on` is 0, while `mode_o` already shows the new mode.
- R8: `mode_o` encodes normal as 2'b00, sink as 2'b01 and source as 2'b10. The value 2'b11 never appears.
- R9: The thresholds are exact. A difference of +2 or -4 stays normal, +3 gives sink and -5 gives source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_vld | input | 1 | Strobe marking a new ADC sample |
| sample_code | input | ADC_W | Digitized regulated quantity |
| ref_code | input | ADC_W | Reference code |
| pwm_in | input | NPH | Per-phase commands from the linear PWM path |
| phase_hi | output | NPH | Per-phase high-side switch commands |
| clamp_on | output | 1 | Auxiliary clamp switch enable |
| mode_o | output | 2 | Current drive mode (status for the PID path) |

## Verification
The bench probes both sides of each threshold (+2/+3 and -4/-5). An off-by-one comparator would flip into a forced mode one bin too early, or stay linear one bin too long. It applies codes at opposite ends of the range, where an unsigned difference would wrap and send the converter into the wrong saturated state. It strobes a sink-to-source jump and a source-to-sink jump and expects the single all-low, clamp-open guard cycle; a design without the guard would command the high side on while the clamp still conducts. It also presents large errors without the strobe, which a design that reacts to unstrobed codes would wrongly act on.

// File: rtl/stv_pkg.sv
package stv_pkg;
  // Drive mode of the override controller; encoding is visible on mode_o.
  typedef enum logic [1:0] {
    MODE_NORM = 2'b00,
    MODE_SINK = 2'b01,
    MODE_SRC  = 2'b10
  } ovr_mode_e;
endpackage

// File: rtl/stv_classify.sv
module stv_classify
  import stv_pkg::*;
#(
  parameter int ADC_W      = 10,
  parameter int OVER_BINS  = 2,
  parameter int UNDER_BINS = 4
) (
  input  logic [ADC_W-1:0] sample_code,
  input  logic [ADC_W-1:0] ref_code,
  output ovr_mode_e        verdict,
  output logic             over_w,
  output logic             under_w
);
  localparam int DW = ADC_W + 1;
  localparam logic signed [DW-1:0] OVER_LIM  = DW'(OVER_BINS);
  localparam logic signed [DW-1:0] UNDER_LIM = DW'(-UNDER_BINS);

  // Signed error in bins, one bit wider so that no code pair wraps.
  function automatic logic signed [DW-1:0] bin_error(
    input logic [ADC_W-1:0] s,
    input logic [ADC_W-1:0] r
  );
    return $signed({1'b0, s}) - $signed({1'b0, r});
  endfunction

  function automatic logic above_window(input logic signed [DW-1:0] e);
    return e > OVER_LIM;
  endfunction

  function automatic logic below_window(input logic signed [DW-1:0] e);
    return e < UNDER_LIM;
  endfunction

  logic signed [DW-1:0] err_w;

  always_comb begin
    err_w   = bin_error(sample_code, ref_code);
    over_w  = above_window(err_w);
    under_w = below_window(err_w);
    if (over_w)       verdict = MODE_SINK;
    else if (under_w) verdict = MODE_SRC;
    else              verdict = MODE_NORM;
  end
endmodule

// File: rtl/stv_mode_fsm.sv
module stv_mode_fsm
  import stv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      strobe,
  input  ovr_mode_e verdict,
  output ovr_mode_e mode_q,
  output logic      blank_q
);
  // True when a step goes straight from one forced rail to the opposite one.
  function automatic logic is_cross(input ovr_mode_e cur, input ovr_mode_e nxt);
    return ((cur == MODE_SINK) && (nxt == MODE_SRC)) ||
           ((cur == MODE_SRC)  && (nxt == MODE_SINK));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_NORM;
      blank_q <= 1'b0;
    end else begin
      blank_q <= strobe && is_cross(mode_q, verdict);
      if (strobe) mode_q <= verdict;
    end
  end
endmodule

// File: rtl/stv_drive.sv
module stv_drive
  import stv_pkg::*;
#(
  parameter int NPH = 4
) (
  input  ovr_mode_e        mode,
  input  logic             blank,
  input  logic [NPH-1:0]   pwm_in,
  output logic [NPH-1:0]   phase_hi,
  output logic             clamp_on
);
  for (genvar g = 0; g < NPH; g++) begin : g_leg
    always_comb begin
      if (blank) phase_hi[g] = 1'b0;
      else begin
        unique case (mode)
          MODE_SINK: phase_hi[g] = 1'b0;
          MODE_SRC:  phase_hi[g] = 1'b1;
          default:   phase_hi[g] = pwm_in[g];
        endcase
      end
    end
  end

  assign clamp_on = (mode == MODE_SINK) && !blank;
endmodule

// File: rtl/stv_override_ctrl.sv
module stv_override_ctrl
  import stv_pkg::*;
#(
  parameter int NPH        = 4,
  parameter int ADC_W      = 10,
  parameter int OVER_BINS  = 2,
  parameter int UNDER_BINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_vld,
  input  logic [ADC_W-1:0] sample_code,
  input  logic [ADC_W-1:0] ref_code,
  input  logic [NPH-1:0]   pwm_in,
  output logic [NPH-1:0]   phase_hi,
  output logic             clamp_on,
  output logic [1:0]       mode_o
);
  ovr_mode_e verdict_w;
  ovr_mode_e mode_w;
  logic      over_w;
  logic      under_w;
  logic      blank_w;

  stv_classify #(
    .ADC_W(ADC_W), .OVER_BINS(OVER_BINS), .UNDER_BINS(UNDER_BINS)
  ) cls_i (
    .sample_code(sample_code),
    .ref_code   (ref_code),
    .verdict    (verdict_w),
    .over_w     (over_w),
    .under_w    (under_w)
  );

  stv_mode_fsm fsm_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (sample_vld),
    .verdict(verdict_w),
    .mode_q (mode_w),
    .blank_q(blank_w)
  );

  stv_drive #(.NPH(NPH)) drv_i (
    .mode    (mode_w),
    .blank   (blank_w),
    .pwm_in  (pwm_in),
    .phase_hi(phase_hi),
    .clamp_on(clamp_on)
  );

  assign mode_o = mode_w;
endmodule

// File: rtl/stv_override_chk.sv
module stv_override_chk #(
  parameter int NPH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sample_vld,
  input logic           over_w,
  input logic           under_w,
  input logic           blank_w,
  input logic [NPH-1:0] pwm_in,
  input logic [NPH-1:0] phase_hi,
  input logic           clamp_on,
  input logic [1:0]     mode_o
);
  assert_sink_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_on |-> (phase_hi == '0) && (mode_o == 2'b01));

  assert_src_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10 && $past(mode_o) != 2'b01) |-> (&phase_hi) && !clamp_on);

  assert_norm_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b00) |-> (phase_hi == pwm_in) && !clamp_on);

  assert_hold_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> $stable(mode_o));

  assert_window_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(over_w && under_w));

  assert_cross_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'b00 && $past(mode_o) != 2'b00 && mode_o != $past(mode_o))
      |-> (phase_hi == '0) && !clamp_on && blank_w);

  assert_mode_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'b11);
endmodule

bind stv_override_ctrl stv_override_chk #(.NPH(NPH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .sample_vld(sample_vld),
  .over_w    (over_w),
  .under_w   (under_w),
  .blank_w   (blank_w),
  .pwm_in    (pwm_in),
  .phase_hi  (phase_hi),
  .clamp_on  (clamp_on),
  .mode_o    (mode_o)
);

// File: tb/stv_override_ctrl_tb_top.sv
module stv_override_ctrl_tb_top;
  localparam int NPH = 4;
  localparam int AW  = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sample_vld = 1'b0;
  logic [AW-1:0] sample_code = '0;
  logic [AW-1:0] ref_code = '0;
  logic [NPH-1:0] pwm_in = '0;
  logic [NPH-1:0] phase_hi;
  logic           clamp_on;
  logic [1:0]     mode_o;

  always #4 clk = ~clk;

  stv_override_ctrl #(.NPH(NPH), .ADC_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
    .sample_code(sample_code), .ref_code(ref_code), .pwm_in(pwm_in),
    .phase_hi(phase_hi), .clamp_on(clamp_on), .mode_o(mode_o)
  );

  typedef struct {
    logic [NPH-1:0] ph;
    logic           cl;
    logic [1:0]     md;
    string          tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  int mdl = 0;   // bench mode: 0 normal, 1 sink, 2 source
  bit done = 0;

  // Driver: applies one cycle of stimulus and predicts the outputs after the edge.
  task automatic step(input bit vld, input int s, input int r,
                      input logic [NPH-1:0] pwm, input string tag);
    exp_t e;
    int nxt;
    bit guard;
    @(negedge clk);
    sample_vld  = vld;
    sample_code = AW'(s);
    ref_code    = AW'(r);
    pwm_in      = pwm;
    guard = 0;
    if (vld) begin
      if (s - r > 2)       nxt = 1;
      else if (s - r < -4) nxt = 2;
      else                 nxt = 0;
      guard = (mdl == 1 && nxt == 2) || (mdl == 2 && nxt == 1);
      mdl = nxt;
    end
    if (guard)         e.ph = '0;
    else if (mdl == 1) e.ph = '0;
    else if (mdl == 2) e.ph = '1;
    else               e.ph = pwm;
    e.cl  = !guard && (mdl == 1);
    e.md  = 2'(mdl);
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares just after each edge.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (phase_hi !== e.ph || clamp_on !== e.cl || mode_o !== e.md) begin
        bad++;
        $display("FAIL %s: phase=%b clamp=%b mode=%b expected phase=%b clamp=%b mode=%b",
                 e.tag, phase_hi, clamp_on, mode_o, e.ph, e.cl, e.md);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    pwm_in = 4'b0110;
    #1;
    total++;
    if (mode_o !== 2'b00 || clamp_on !== 1'b0 || phase_hi !== 4'b0110) begin
      bad++;
      $display("FAIL R1 reset: mode=%b clamp=%b phase=%b expected 00 0 0110",
               mode_o, clamp_on, phase_hi);
    end
    rst_n = 1'b1;
    step(0, 500, 500, 4'b1001, "R1 after reset");
    step(1, 500, 500, 4'b0101, "R4 zero error");
    step(1, 502, 500, 4'b1010, "R9 +2 stays normal");
    step(1, 496, 500, 4'b0011, "R9 -4 stays normal");
    step(0, 496, 500, 4'b1100, "R4 pwm follows");
    step(1, 503, 500, 4'b1111, "R9 +3 sink R2");
    step(0, 100, 900, 4'b1111, "R5 unstrobed large under");
    step(0, 900, 100, 4'b0101, "R5 unstrobed large over");
    step(1, 495, 500, 4'b1010, "R7 sink to source guard");
    step(0, 495, 500, 4'b0000, "R3 source drive");
    step(0, 600, 500, 4'b0000, "R5 source held");
    step(1, 498, 500, 4'b1000, "R4 back to normal");
    step(1, 495, 500, 4'b0100, "R9 -5 source R3");
    step(1, 800, 10, 4'b0100, "R7 source to sink guard");
    step(1, 800, 10, 4'b0100, "R2 sink after guard");
    step(1, 0, 0, 4'b0001, "R4 normal low codes");
    step(1, 1023, 0, 4'b0001, "R6 full-scale over");
    step(1, 0, 1023, 4'b0010, "R6 full-scale under R7");
    step(1, 0, 1023, 4'b0010, "R6 source held R3");
    step(1, 1023, 1023, 4'b1011, "R4 normal top codes");
    step(0, 1023, 1023, 4'b1011, "R8 normal encoding");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule